// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

The controller collects a set of interrupt condition inputs, one per source, into a status register and one interrupt pin. For each source, software chooses a trigger mode: arrival of the condition, removal of the condition, or the condition's presence. The 2-bit code for source n is built from bit n of the high mode register and bit n of the low mode register. A per-source enable bit decides whether that source can record status and whether it can drive the pin.

Condition inputs are asynchronous. Each one passes through a synchronizer before any edge detection. Edge events stay latched until software reads the status register, and that read clears them. Level-mode bits track the synchronized condition and need no read.

The pin is driven from a registered summary of the enabled status bits. Its electrical sense is set by a separate 2-bit drive-style field and does not depend on the trigger modes.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable, high mode, low mode and drive-style registers are all zero. The status register reads zero, `irqOe` is 1 and `irqOut` is 0.
- R2: Register addresses are: 0 enable, 1 mode high, 2 mode low, 3 drive style (bits 1:0, with upper read bits 0), 4 status (read-only; writes are ignored). Addresses 5 to 7 read zero. `regRdData` is valid in the same cycle as `regRdEn`.
- R3: Code 00 (rising) latches status bit n when condition n goes from 0 to 1. The bit is visible from the third rising clock edge after the new input level is first sampled.
- R4: Code 01 (falling) latches the status bit on a 1-to-0 transition of the condition. A 0-to-1 transition has no effect.
- R5: Code 10 (level) makes the status bit follow the synchronized condition, with the same three-edge latency. The bit is not cleared by a status read.
- R6: Code 11 is reserved. It never sets status and never raises the pin.
- R7: An enable bit of 0 stops its source from setting status and from driving the pin. Enable bit n corresponds to status bit n.
- R8: Reading address 4 clears every latched edge bit at the clock edge that ends the read. An edge event landing on that same edge still sets its bit.
- R9: The internal request goes active one clock edge after any enabled status bit is set. It goes inactive one clock edge after all enabled status bits are clear.
- R10: Drive style 00 gives active-high output (`irqOe`=1). Style 01 gives active-low output (`irqOe`=1). Style 10 gives open-drain output: `irqOut`=0, and `irqOe` equals the request. Style 11 drives `irqOut`=0 and `irqOe`=0.
- R11: A condition that is already high when reset is released does not produce a rising-edge event.
- R12: The trigger code for source n is {mode high bit n, mode low bit n}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| condIn | input | NUM_SRC | Asynchronous interrupt conditions, one per source |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 4 clears latched edges) |
| regAddr | input | 3 | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, combinational, zero when not reading |
| irqOut | output | 1 | Interrupt pin data |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
On every cycle, the bound checker confirms four properties. The pin never drives data while its enable is low. The reserved and open-drain styles never drive a high level. Status reads never show bits for sources that were disabled. Unmapped and partially used registers read back zero bits. Only the bench scenarios can show the three-edge trigger latency, the arrival/removal/level selection per source, the set-wins-over-clear corner, the one-cycle pin release, and the absence of a spurious edge for a condition held high through reset.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [2:0] {
    ADDR_ENABLE  = 3'd0,
    ADDR_MODE_HI = 3'd1,
    ADDR_MODE_LO = 3'd2,
    ADDR_DRIVE   = 3'd3,
    ADDR_STATUS  = 3'd4
  } regAddr_e;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trigMode_e;

  typedef enum logic [1:0] {
    DRV_HIGH  = 2'b00,
    DRV_LOW   = 2'b01,
    DRV_OPEN  = 2'b10,
    DRV_RSVD  = 2'b11
  } drvStyle_e;

  // strobes issued by the register control toward the datapath
  typedef struct packed {
    logic statusClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] statusIn,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_SRC-1:0] enableOut,
  output logic [NUM_SRC-1:0] modeHiOut,
  output logic [NUM_SRC-1:0] modeLoOut,
  output drvStyle_e          driveOut,
  output ctrlStrobe_t        strobe
);

  localparam int unsigned DRV_W = 2;

  logic [NUM_SRC-1:0] enableReg;
  logic [NUM_SRC-1:0] modeHiReg;
  logic [NUM_SRC-1:0] modeLoReg;
  drvStyle_e          driveReg;

  // configuration registers; writes to the status address fall through
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      modeHiReg <= '0;
      modeLoReg <= '0;
      driveReg  <= DRV_HIGH;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_ENABLE:  enableReg <= regWrData[NUM_SRC-1:0];
        ADDR_MODE_HI: modeHiReg <= regWrData[NUM_SRC-1:0];
        ADDR_MODE_LO: modeLoReg <= regWrData[NUM_SRC-1:0];
        ADDR_DRIVE:   driveReg  <= drvStyle_e'(regWrData[DRV_W-1:0]);
        default: ;
      endcase
    end
  end

  // read mux, zero-extended per register
  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        ADDR_ENABLE:  regRdData = DATA_W'(enableReg);
        ADDR_MODE_HI: regRdData = DATA_W'(modeHiReg);
        ADDR_MODE_LO: regRdData = DATA_W'(modeLoReg);
        ADDR_DRIVE:   regRdData = DATA_W'(driveReg);
        ADDR_STATUS:  regRdData = DATA_W'(statusIn);
        default:      regRdData = '0;
      endcase
    end
  end

  always_comb begin
    strobe.statusClr = regRdEn && (regAddr == ADDR_STATUS);
  end

  assign enableOut = enableReg;
  assign modeHiOut = modeHiReg;
  assign modeLoOut = modeLoReg;
  assign driveOut  = driveReg;

endmodule

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic [NUM_SRC-1:0] enableIn,
  input  logic [NUM_SRC-1:0] modeHiIn,
  input  logic [NUM_SRC-1:0] modeLoIn,
  input  drvStyle_e          driveIn,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] statusOut,
  output logic               irqOut,
  output logic               irqOe
);

  // edge detection is valid once the synchronizer and the previous-value
  // register both hold post-reset samples
  localparam int unsigned ARM_LIMIT = SYNC_STAGES + 1;
  localparam int unsigned ARM_W     = $clog2(ARM_LIMIT + 1);

  logic [ARM_W-1:0]   armCnt;
  logic               armed;
  logic [NUM_SRC-1:0] liveCond;
  logic [NUM_SRC-1:0] prevCond;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] statusNext;
  logic               reqActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (armCnt != ARM_W'(ARM_LIMIT)) begin
      armCnt <= armCnt + 1'b1;
    end
  end

  assign armed = (armCnt == ARM_W'(ARM_LIMIT));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      logic [SYNC_STAGES-1:0] syncQ;
      trigMode_e              trig;
      logic                   riseEv;
      logic                   fallEv;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ <= '0;
        end else begin
          syncQ <= {syncQ[SYNC_STAGES-2:0], condIn[gi]};
        end
      end

      assign liveCond[gi] = syncQ[SYNC_STAGES-1];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevCond[gi] <= 1'b0;
        end else begin
          prevCond[gi] <= liveCond[gi];
        end
      end

      assign trig   = trigMode_e'({modeHiIn[gi], modeLoIn[gi]});
      assign riseEv = armed &  liveCond[gi] & ~prevCond[gi];
      assign fallEv = armed & ~liveCond[gi] &  prevCond[gi];

      // new events win over a clear on the same edge
      always_comb begin
        case (trig)
          TRIG_RISE:  statusNext[gi] = (statusQ[gi] & ~strobe.statusClr) | riseEv;
          TRIG_FALL:  statusNext[gi] = (statusQ[gi] & ~strobe.statusClr) | fallEv;
          TRIG_LEVEL: statusNext[gi] = liveCond[gi];
          default:    statusNext[gi] = 1'b0;
        endcase
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusQ[gi] <= 1'b0;
        end else begin
          statusQ[gi] <= statusNext[gi] & enableIn[gi];
        end
      end
    end
  endgenerate

  // registered request keeps the pin free of decode glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqActive <= 1'b0;
    end else begin
      reqActive <= |(statusQ & enableIn);
    end
  end

  always_comb begin
    case (driveIn)
      DRV_HIGH: begin irqOut = reqActive;  irqOe = 1'b1;      end
      DRV_LOW:  begin irqOut = ~reqActive; irqOe = 1'b1;      end
      DRV_OPEN: begin irqOut = 1'b0;       irqOe = reqActive; end
      default:  begin irqOut = 1'b0;       irqOe = 1'b0;      end
    endcase
  end

  assign statusOut = statusQ;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut,
  output logic               irqOe
);

  logic [NUM_SRC-1:0] enableW;
  logic [NUM_SRC-1:0] modeHiW;
  logic [NUM_SRC-1:0] modeLoW;
  logic [NUM_SRC-1:0] statusW;
  drvStyle_e          driveW;
  ctrlStrobe_t        strobeW;

  irq_ctrl_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .statusIn  (statusW),
    .regRdData (regRdData),
    .enableOut (enableW),
    .modeHiOut (modeHiW),
    .modeLoOut (modeLoW),
    .driveOut  (driveW),
    .strobe    (strobeW)
  );

  irq_ctrl_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .condIn    (condIn),
    .enableIn  (enableW),
    .modeHiIn  (modeHiW),
    .modeLoIn  (modeLoW),
    .driveIn   (driveW),
    .strobe    (strobeW),
    .statusOut (statusW),
    .irqOut    (irqOut),
    .irqOe     (irqOe)
  );

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] condIn,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [2:0]         regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic               irqOut,
  input logic               irqOe
);

  // shadow of the write side, rebuilt from the port traffic
  logic [NUM_SRC-1:0] shadowEnable;
  logic [NUM_SRC-1:0] prevEnable;
  logic [1:0]         shadowDrive;
  logic               condSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowEnable <= '0;
      prevEnable   <= '0;
      shadowDrive  <= 2'b00;
      condSeen     <= 1'b0;
    end else begin
      prevEnable <= shadowEnable;
      condSeen   <= |condIn;
      if (regWrEn && regAddr == 3'd0) shadowEnable <= regWrData[NUM_SRC-1:0];
      if (regWrEn && regAddr == 3'd3) shadowDrive  <= regWrData[1:0];
    end
  end

  logic statusRead;
  assign statusRead = regRdEn && (regAddr == 3'd4);

  assert_pin_idle_after_reset_R1: assert property (
    @(posedge clk) $rose(rstN) |-> (irqOe && !irqOut || condSeen));

  assert_unmapped_reads_zero_R2: assert property (
    @(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr > 3'd4) |-> (regRdData == '0));

  assert_drive_field_width_R2: assert property (
    @(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd3) |-> (regRdData[DATA_W-1:2] == '0));

  assert_disabled_sources_silent_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    statusRead |-> ((regRdData & ~DATA_W'(prevEnable)) == '0));

  assert_no_data_without_enable_R10: assert property (
    @(posedge clk) disable iff (!rstN)
    !irqOe |-> !irqOut);

  assert_open_drain_never_high_R10: assert property (
    @(posedge clk) disable iff (!rstN)
    (shadowDrive == 2'b10) |-> !irqOut);

  assert_reserved_drive_quiet_R10: assert property (
    @(posedge clk) disable iff (!rstN)
    (shadowDrive == 2'b11) |-> (!irqOut && !irqOe));

  assert_push_pull_enabled_R10: assert property (
    @(posedge clk) disable iff (!rstN)
    (shadowDrive[1] == 1'b0) |-> irqOe);

endmodule

bind irq_ctrl irq_ctrl_checker #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .condIn    (condIn),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .irqOe     (irqOe)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 8;
  localparam int DW         = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NSRC-1:0] condIn;
  logic            regWrEn;
  logic            regRdEn;
  logic [2:0]      regAddr;
  logic [DW-1:0]   regWrData;
  logic [DW-1:0]   regRdData;
  logic            irqOut;
  logic            irqOe;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [DW-1:0] expQ[$];
  string         tagQ[$];

  irq_ctrl u_irq_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condIn    (condIn),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .irqOe     (irqOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (regRdEn && rstN) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected read actual=%h expected=none", regRdData);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, regRdData, e);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [DW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, logic [DW-1:0] e, string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    regRdEn = 1'b1; regAddr = a;
    step(1);
    regRdEn = 1'b0;
  endtask

  task automatic checkPin(logic eOut, logic eOe, string tag);
    checks++;
    if (irqOut !== eOut || irqOe !== eOe) begin
      failures++;
      $display("FAIL %s actual=out%b/oe%b expected=out%b/oe%b",
               tag, irqOut, irqOe, eOut, eOe);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; condIn = 8'h01; regWrEn = 1'b0; regRdEn = 1'b0;
    regAddr = '0; regWrData = '0;
    step(3);
    checkPin(1'b0, 1'b1, "R1 pin during reset");
    rstN = 1'b1;
    // R1 reset values; R11 source 0 held high through reset
    regRead(3'd0, 8'h00, "R1 enable reset");
    regWrite(3'd0, 8'hFF);
    regRead(3'd1, 8'h00, "R1 mode high reset");
    regRead(3'd2, 8'h00, "R1 mode low reset");
    regRead(3'd3, 8'h00, "R1 drive reset");
    step(4);
    regRead(3'd4, 8'h00, "R11 no false edge after reset");
    checkPin(1'b0, 1'b1, "R11 pin quiet");
    condIn = 8'h00; step(4);
    regRead(3'd4, 8'h00, "R3 fall ignored in rising mode");

    // R3 rising, R8 set wins over clear and clear on read
    condIn[1] = 1'b1; step(2);
    regRead(3'd4, 8'h00, "R8 read before event lands");
    regRead(3'd4, 8'h02, "R3 R8 event kept across clear edge");
    regRead(3'd4, 8'h00, "R8 cleared by read");

    // R4 falling on source 2 (mode low bit 2)
    regWrite(3'd2, 8'h04);
    condIn[2] = 1'b1; step(5);
    regRead(3'd4, 8'h00, "R4 R12 rise ignored in falling mode");
    condIn[2] = 1'b0; step(3);
    regRead(3'd4, 8'h04, "R4 R12 falling edge latched");
    regRead(3'd4, 8'h00, "R4 cleared");

    // R5 level on source 3 (mode high bit 3)
    regWrite(3'd1, 8'h08);
    condIn[3] = 1'b1; step(3);
    regRead(3'd4, 8'h08, "R5 R12 level present");
    regRead(3'd4, 8'h08, "R5 level survives read");
    condIn[3] = 1'b0; step(3);
    regRead(3'd4, 8'h00, "R5 level follows removal");

    // R6 reserved code on source 4
    regWrite(3'd1, 8'h18);
    regWrite(3'd2, 8'h14);
    condIn[4] = 1'b1; step(5);
    regRead(3'd4, 8'h00, "R6 R12 reserved ignores rise");
    condIn[4] = 1'b0; step(5);
    regRead(3'd4, 8'h00, "R6 reserved ignores fall");
    checkPin(1'b0, 1'b1, "R6 pin quiet");

    // R7 disabled source 1
    condIn[1] = 1'b0; step(4);
    regRead(3'd4, 8'h00, "R7 prep");
    regWrite(3'd0, 8'hFD);
    condIn[1] = 1'b1; step(5);
    regRead(3'd4, 8'h00, "R7 disabled source blocked");
    checkPin(1'b0, 1'b1, "R7 pin blocked");

    // R9 pin timing on source 5
    regWrite(3'd0, 8'hFF);
    condIn[5] = 1'b1; step(3);
    checkPin(1'b0, 1'b1, "R9 pin not yet");
    step(1);
    checkPin(1'b1, 1'b1, "R9 pin raised");
    regRead(3'd4, 8'h20, "R9 status source 5");
    checkPin(1'b1, 1'b1, "R9 pin held one cycle");
    step(1);
    checkPin(1'b0, 1'b1, "R9 pin released");

    // R10 drive styles, request held by level source 3
    condIn[3] = 1'b1; step(4);
    checkPin(1'b1, 1'b1, "R10 active high");
    regWrite(3'd3, 8'h01);
    checkPin(1'b0, 1'b1, "R10 active low asserted");
    regWrite(3'd3, 8'h02);
    checkPin(1'b0, 1'b1, "R10 open drain asserted");
    condIn[3] = 1'b0; step(5);
    checkPin(1'b0, 1'b0, "R10 open drain released");
    condIn[3] = 1'b1; step(5);
    regWrite(3'd3, 8'h03);
    checkPin(1'b0, 1'b0, "R10 reserved style");
    regWrite(3'd3, 8'h01);
    condIn[3] = 1'b0; step(5);
    checkPin(1'b1, 1'b1, "R10 active low idle");

    // R2 map, read-only status, unmapped addresses
    regWrite(3'd3, 8'hFE);
    regRead(3'd3, 8'h02, "R2 drive field width");
    regRead(3'd0, 8'hFF, "R2 enable readback");
    regRead(3'd1, 8'h18, "R2 mode high readback");
    regRead(3'd2, 8'h14, "R2 mode low readback");
    regWrite(3'd4, 8'hFF);
    regRead(3'd4, 8'h00, "R2 status write ignored");
    regRead(3'd5, 8'h00, "R2 unmapped 5");
    regRead(3'd7, 8'h00, "R2 unmapped 7");

    step(2);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule